// File: doc/BRIEF.md
# Bridge Control Register Bank

This block is the word-addressed control and status register bank of a host bridge. A master reaches it over a plain 32-bit bus with separate read and write strobes and a byte offset. Every access is a full word, and the two low offset bits are ignored. Most words are ordinary read/write storage. Their contents are brought out as one flat vector, so the surrounding logic can use them directly.

Two words behave differently. The interrupt enable word cannot be written directly. It changes only through a set alias, whose written ones are ORed in, and a clear alias, whose written ones are removed. Both aliases also keep the last value written to them. The interrupt status word is read-only.

The general configuration word watches bit 2. A write that takes this bit from 0 to 1 produces a single-cycle system reset request. The written value is stored in either case.

Top module: `bridge_csr_bank`

## Requirements
- R1: After reset the words hold these values: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other word, including the enable word (0x38), is 0.
- R2: A write to an ordinary word stores all 32 bits. A read returns the stored word on rdata_o one cycle after rd_en_i is sampled.
- R3: A write to the set alias (0x30) stores the value at 0x30 and ORs it into the enable word (0x38).
- R4: A write to the clear alias (0x34) stores the value at 0x34 and clears the written one bits in the enable word. The value stored at 0x30 is left unchanged.
- R5: Writes to the enable word (0x38) and the status word (0x3C) have no effect. The status word reads 0.
- R6: A write to an offset at or above 0x70 changes no word. A read from such an offset returns 0.
- R7: A write to 0x04 with bit 2 set, while the stored bit 2 is 0, drives rst_req_o high for exactly the one cycle after the write edge. The written value is stored.
- R8: A write to 0x04 that leaves bit 2 at 0, or that finds bit 2 already set, raises no reset request.
- R9: regs_o carries word index i (byte offset 4*i) at bits [32*i+31:32*i]. A word's new value appears there in the cycle after the write edge.
- R10: rdata_o holds its value in every cycle in which no read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset; bits [7:2] select the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| regs_o | output | 896 | All 28 words, word i at bits [32*i+31:32*i] |
| rst_req_o | output | 1 | Single-cycle system reset request |

## Verification
Every result is due exactly one clock edge after its stimulus is sampled:
- read data follows one edge after the read strobe;
- a written value appears on regs_o one edge after the write;
- the reset request rises one edge after the triggering write and falls on the following edge.

The bench drives inputs at the falling edge and samples at the next falling edge, so it reads each result in the cycle where it first becomes due. Where timing itself is the point, it also samples before the edge, to confirm the old value is still present. For the reset pulse and the read hold, it samples again one cycle later.

// File: rtl/bridge_csr_pkg.sv
package bridge_csr_pkg;

  localparam int CSR_DW      = 32;
  localparam int CSR_WORDS   = 28;
  localparam int IDX_GENCFG  = 1;
  localparam int IDX_EN_SET  = 12;
  localparam int IDX_EN_CLR  = 13;
  localparam int IDX_EN      = 14;
  localparam int IDX_STATUS  = 15;
  localparam int RST_REQ_BIT = 2;

  typedef enum logic [2:0] {
    KIND_RW,
    KIND_SET,
    KIND_CLR,
    KIND_EN,
    KIND_STAT
  } word_kind_e;

  function automatic word_kind_e word_kind(input int idx);
    case (idx)
      IDX_EN_SET: return KIND_SET;
      IDX_EN_CLR: return KIND_CLR;
      IDX_EN:     return KIND_EN;
      IDX_STATUS: return KIND_STAT;
      default:    return KIND_RW;
    endcase
  endfunction

  function automatic logic [CSR_DW-1:0] word_init(input int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 28,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_WORDS-1:0] word_wr_o
);
  import bridge_csr_pkg::*;

  logic unused_low;
  assign unused_low = ^addr_i[1:0];
  assign idx_o = addr_i[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_strobe
    localparam word_kind_e KIND = word_kind(i);
    if (KIND == KIND_EN || KIND == KIND_STAT) begin : g_ro
      assign word_wr_o[i] = 1'b0;
    end else begin : g_wr
      assign word_wr_o[i] = wr_en_i && (idx_o == IDX_W'(i));
    end
  end

endmodule

// File: rtl/csr_irq_enable.sv
module csr_irq_enable #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_o
);

  logic [DATA_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (set_i) begin
      en_q <= en_q | wdata_i;
    end else if (clr_i) begin
      en_q <= en_q & ~wdata_i;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/csr_reset_pulse.sv
module csr_reset_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_wr_i,
  input  logic new_bit_i,
  input  logic old_bit_i,
  output logic req_o
);

  logic req_q;

  // rising edge of the stored bit, caused by this write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= gen_wr_i && new_bit_i && !old_bit_i;
  end

  assign req_o = req_q;

endmodule

// File: rtl/csr_word_bank.sv
module csr_word_bank #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 28
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WORDS-1:0] word_wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    words_o [NUM_WORDS]
);
  import bridge_csr_pkg::*;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam word_kind_e KIND = word_kind(i);
    if (KIND == KIND_EN) begin : g_en
      csr_irq_enable #(.DATA_W(DATA_W)) i_en (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (word_wr_i[IDX_EN_SET]),
        .clr_i   (word_wr_i[IDX_EN_CLR]),
        .wdata_i (wdata_i),
        .en_o    (words_o[i])
      );
    end else if (KIND == KIND_STAT) begin : g_stat
      assign words_o[i] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           q <= DATA_W'(word_init(i));
        else if (word_wr_i[i]) q <= wdata_i;
      end
      assign words_o[i] = q;
    end
  end

endmodule

// File: rtl/bridge_csr_bank.sv
module bridge_csr_bank #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = bridge_csr_pkg::CSR_DW,
  parameter int NUM_WORDS = bridge_csr_pkg::CSR_WORDS,
  localparam int IDX_W    = ADDR_W - 2,
  localparam int FLAT_W   = DATA_W * NUM_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FLAT_W-1:0] regs_o,
  output logic              rst_req_o
);
  import bridge_csr_pkg::*;

  logic [IDX_W-1:0]     idx;
  logic [NUM_WORDS-1:0] word_wr;
  logic [DATA_W-1:0]    words [NUM_WORDS];
  logic [DATA_W-1:0]    rd_sel;
  logic [DATA_W-1:0]    rdata_q;

  csr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) i_decode (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .idx_o     (idx),
    .word_wr_o (word_wr)
  );

  csr_word_bank #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_wr_i (word_wr),
    .wdata_i   (wdata_i),
    .words_o   (words)
  );

  csr_reset_pulse i_rst_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gen_wr_i  (word_wr[IDX_GENCFG]),
    .new_bit_i (wdata_i[RST_REQ_BIT]),
    .old_bit_i (words[IDX_GENCFG][RST_REQ_BIT]),
    .req_o     (rst_req_o)
  );

  // unmapped indices match no word and read 0
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (idx == IDX_W'(i)) rd_sel = words[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_sel;
  end

  assign rdata_o = rdata_q;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_flat
    assign regs_o[i*DATA_W +: DATA_W] = words[i];
  end

endmodule

// File: rtl/bridge_csr_chk.sv
module bridge_csr_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 28,
  localparam int IDX_W    = ADDR_W - 2,
  localparam int FLAT_W   = DATA_W * NUM_WORDS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [FLAT_W-1:0] regs_o,
  input logic              rst_req_o
);
  import bridge_csr_pkg::*;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] en_w;
  logic              alias_wr;
  logic              gen_old;
  assign idx      = addr_i[ADDR_W-1:2];
  assign en_w     = regs_o[IDX_EN*DATA_W +: DATA_W];
  assign alias_wr = wr_en_i && (idx == IDX_W'(IDX_EN_SET) || idx == IDX_W'(IDX_EN_CLR));
  assign gen_old  = regs_o[IDX_GENCFG*DATA_W + RST_REQ_BIT];

  // R5
  en_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alias_wr |=> $stable(en_w));

  // R3
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx == IDX_W'(IDX_EN_SET)) |=> ((en_w & $past(wdata_i)) == $past(wdata_i)));

  // R4
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx == IDX_W'(IDX_EN_CLR)) |=> ((en_w & $past(wdata_i)) == '0));

  // R7
  rst_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx == IDX_W'(IDX_GENCFG) && wdata_i[RST_REQ_BIT] && !gen_old) |=> rst_req_o);

  // R7
  rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R8
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(wr_en_i && idx == IDX_W'(IDX_GENCFG) && wdata_i[RST_REQ_BIT] && !gen_old));

  // R6
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && idx >= IDX_W'(NUM_WORDS)) |=> (rdata_o == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

endmodule

bind bridge_csr_bank bridge_csr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
) i_chk (.*);

// File: tb/test_bridge_csr_bank.sv
module test_bridge_csr_bank;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NW = 28;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] val;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0000_0C40, 4'd1},  // R1
    '{1'b0, 8'h04, 32'h0000_1384, 4'd1},
    '{1'b0, 8'h08, 32'h2BFF_8010, 4'd1},
    '{1'b0, 8'h0C, 32'h255E_0091, 4'd1},
    '{1'b0, 8'h10, 32'h0000_6140, 4'd1},
    '{1'b0, 8'h14, 32'h0000_0000, 4'd1},
    '{1'b0, 8'h1C, 32'h0000_01FF, 4'd1},
    '{1'b0, 8'h20, 32'h0000_01FF, 4'd1},
    '{1'b0, 8'h68, 32'h0000_0008, 4'd1},
    '{1'b0, 8'h6C, 32'h1000_0000, 4'd1},
    '{1'b0, 8'h38, 32'h0000_0000, 4'd1},
    '{1'b1, 8'h40, 32'hDEAD_BEEF, 4'd2},  // R2
    '{1'b0, 8'h40, 32'hDEAD_BEEF, 4'd2},
    '{1'b1, 8'h60, 32'h1234_5678, 4'd2},
    '{1'b0, 8'h60, 32'h1234_5678, 4'd2},
    '{1'b1, 8'h1C, 32'h0000_0000, 4'd2},
    '{1'b0, 8'h1C, 32'h0000_0000, 4'd2},
    '{1'b1, 8'h30, 32'h0000_00F3, 4'd3},  // R3
    '{1'b0, 8'h30, 32'h0000_00F3, 4'd3},
    '{1'b0, 8'h38, 32'h0000_00F3, 4'd3},
    '{1'b1, 8'h30, 32'h0000_0F00, 4'd3},
    '{1'b0, 8'h38, 32'h0000_0FF3, 4'd3},
    '{1'b1, 8'h34, 32'h0000_0031, 4'd4},  // R4
    '{1'b0, 8'h34, 32'h0000_0031, 4'd4},
    '{1'b0, 8'h38, 32'h0000_0FC2, 4'd4},
    '{1'b1, 8'h38, 32'hFFFF_FFFF, 4'd5},  // R5
    '{1'b0, 8'h38, 32'h0000_0FC2, 4'd5},
    '{1'b1, 8'h3C, 32'hFFFF_FFFF, 4'd5},
    '{1'b0, 8'h3C, 32'h0000_0000, 4'd5},
    '{1'b1, 8'h70, 32'hAAAA_5555, 4'd6},  // R6
    '{1'b0, 8'h70, 32'h0000_0000, 4'd6},
    '{1'b0, 8'hFC, 32'h0000_0000, 4'd6},
    '{1'b0, 8'h30, 32'h0000_0F00, 4'd4}   // R4: set alias keeps its last value
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic           rd_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic [DW*NW-1:0] regs;
  logic           rst_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  bridge_csr_bank i_bridge_csr_bank (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .regs_o    (regs),
    .rst_req_o (rst_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [DW-1:0] word_of(input int i);
    return regs[i*DW +: DW];
  endfunction

  initial begin
    logic [DW*NW-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R9: reset values visible on the flat output
    check("R1", word_of(0), 32'h0000_0C40);
    check("R9", word_of(27), 32'h1000_0000);
    check("R1", {31'b0, rst_req}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) begin
        do_write(VECS[k].addr, VECS[k].val);
      end else begin
        do_read(VECS[k].addr);
        check($sformatf("R%0d vec%0d", VECS[k].req, k), rdata, VECS[k].val);
      end
    end

    // R6: an unmapped write leaves every word untouched
    snap = regs;
    do_write(8'h74, 32'h5A5A_5A5A);
    total = total + 1;
    if (regs !== snap) begin
      bad = bad + 1;
      $display("FAIL R6 act=%h exp=%h", regs[DW-1:0], snap[DW-1:0]);
    end

    // R9: new value appears only after the write edge
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h44; wdata = 32'h0000_0055;
    #1 check("R9 before edge", word_of(17), 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 after edge", word_of(17), 32'h0000_0055);

    // R8: bit 2 already set at reset, rewriting it raises nothing
    do_write(8'h04, 32'h0000_1384);
    check("R8 already set", {31'b0, rst_req}, 32'h0);
    do_write(8'h04, 32'h0000_0000);
    check("R8 write zero", {31'b0, rst_req}, 32'h0);
    check("R8 stored", word_of(1), 32'h0);

    // R7: 0 -> 1 gives one pulse, value stored
    do_write(8'h04, 32'h0000_0004);
    check("R7 pulse high", {31'b0, rst_req}, 32'h1);
    check("R7 stored", word_of(1), 32'h0000_0004);
    @(negedge clk);
    check("R7 pulse low", {31'b0, rst_req}, 32'h0);

    // R10: read data holds with no read, even across a write
    do_read(8'h00);
    check("R10 read", rdata, 32'h0000_0C40);
    do_write(8'h00, 32'h0000_0001);
    @(negedge clk);
    check("R10 hold", rdata, 32'h0000_0C40);
    do_read(8'h00);
    check("R2 new value", rdata, 32'h0000_0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule